// File: doc/BRIEF.md
# Pipelined No-Wait Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous burst static RAM. Address, control and byte write enables are registered on the rising clock edge. Read data comes out of a register two enabled edges after its address. Write data is taken from the input bus on the same relative edge. Because both directions use the same pipeline depth, a read may follow a write, and a write may follow a read, on the very next cycle without any idle turnaround.

A burst starts when the load input is low and all three chip selects agree. A two-bit beat counter then steps the low address bits on each cycle with the load input high. It follows either an interleaved (XOR) order or a linear (wrapping increment) order. A clock-enable input freezes the whole block, and an output-enable input gates the data drive without touching the pipeline. The shared data bus is split into an input bus, an output bus and a drive enable.

Top module: `nw_burst_sram`

## Requirements
- R1: A burst starts only on an enabled edge with `load_n`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load edge with any other select combination deselects the block, and no access is made.
- R2: On a load edge the external address is captured and the beat counter is cleared to 0. On an enabled edge with `load_n`=1 while a burst is live, the counter advances by one modulo 4 and the burst keeps its read or write type.
- R3: While `clk_en_n`=1, every synchronous input is ignored. The counter, the pipeline, the output register and the array all keep their values.
- R4: `wr_n`=0 on a load edge makes the burst a write, and `wr_n`=1 makes it a read. Lane i is `wdata[8i+7:8i]`, and it is written only when `lane_wr_n[i]`=0 on that beat's address edge.
- R5: A write beat with every `lane_wr_n` bit at 1 is aborted and leaves the array unchanged.
- R6: Read data and `rdata_oe` reflect a read beat after the second enabled edge following its address edge. Write data is sampled on the second enabled edge after the write beat's address edge. A read issued on the cycle right after a write to the same word returns the new data.
- R7: With `order_ilv`=1, the low two address bits of beat n are base XOR n. With `order_ilv`=0, they are (base + n) mod 4. The upper address bits stay at the loaded value.
- R8: After a deselect, edges with `load_n`=1 keep the block deselected, whatever the chip selects show. After reset the block is deselected.
- R9: `rdata_oe` is 1 only when the output register holds read data and `out_en_n`=0. It follows `out_en_n` combinationally. A read issued with `out_en_n`=1 still runs through the pipeline.
- R10: Synchronous reset clears the pipeline and the burst state, so `rdata_oe` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Low enables the clock edge; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new address; high advances the burst |
| wr_n | input | 1 | Low selects write, high selects read, at a load edge |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low, acts combinationally |
| order_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr | input | AW | Word address |
| wdata | input | LANES*LW | Write data bus |
| rdata | output | LANES*LW | Read data register |
| rdata_oe | output | 1 | Drive enable for the read data |

## Verification
The bench builds the block with AW=5, LANES=2, LW=8 and LATENCY=2. The 32-word array gives enough room for several 4-word blocks at distinct upper addresses, so interleaved and linear bursts can be told apart by the words they land on. Two lanes are enough to show a partial write next to a fully masked one. The latency of two exposes read-after-write on consecutive cycles, and it shows stalls inserted between the address edge and the data edge.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;

    // Low address bits of a beat: XOR order or wrapping increment order.
    function automatic beat_t beat_offset(input beat_t base, input beat_t cnt, input logic ilv);
        beat_t r;
        if (ilv) r = base ^ cnt;
        else     r = beat_t'(base + cnt);
        return r;
    endfunction

endpackage

// File: rtl/nwsram_cmd.sv
module nwsram_cmd
    import nwsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_en,
    input  logic          sel_ok,
    input  logic          load_n,
    input  logic          wr_n,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    output op_e           iss_op,
    output logic [AW-1:0] iss_addr,
    output logic          burst_live,
    output beat_t         burst_cnt
);

    logic          live_q, live_d;
    logic          wr_q, wr_d;
    logic [AW-1:0] base_q, base_d;
    beat_t         cnt_q, cnt_d;

    always_comb begin
        if (!load_n) begin
            live_d = sel_ok;
            wr_d   = ~wr_n;
            base_d = addr;
            cnt_d  = '0;
        end else begin
            live_d = live_q;
            wr_d   = wr_q;
            base_d = base_q;
            cnt_d  = live_q ? beat_t'(cnt_q + 1'b1) : cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            wr_q   <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (adv_en) begin
            live_q <= live_d;
            wr_q   <= wr_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    assign iss_op     = !live_d ? OP_IDLE : (wr_d ? OP_WRITE : OP_READ);
    assign iss_addr   = {base_d[AW-1:BEAT_W], beat_offset(base_d[BEAT_W-1:0], cnt_d, ilv)};
    assign burst_live = live_q;
    assign burst_cnt  = cnt_q;

endmodule

// File: rtl/nwsram_pipe.sv
module nwsram_pipe
    import nwsram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  op_e              in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_lane_n,
    output op_e              out_op,
    output logic [AW-1:0]    out_addr,
    output logic [LANES-1:0] out_lane_n
);

    op_e              op_q   [STAGES];
    logic [AW-1:0]    addr_q [STAGES];
    logic [LANES-1:0] lane_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                op_q[s]   <= OP_IDLE;
                addr_q[s] <= '0;
                lane_q[s] <= '1;
            end
        end else if (en) begin
            op_q[0]   <= in_op;
            addr_q[0] <= in_addr;
            lane_q[0] <= in_lane_n;
            for (int s = 1; s < STAGES; s++) begin
                op_q[s]   <= op_q[s-1];
                addr_q[s] <= addr_q[s-1];
                lane_q[s] <= lane_q[s-1];
            end
        end
    end

    assign out_op     = op_q[STAGES-1];
    assign out_addr   = addr_q[STAGES-1];
    assign out_lane_n = lane_q[STAGES-1];

endmodule

// File: rtl/nwsram_array.sv
module nwsram_array #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                en,
    input  logic                wr,
    input  logic [AW-1:0]       addr,
    input  logic [LANES-1:0]    lane_n,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (en && wr && !lane_n[l]) mem[addr] <= wdata[l*LW +: LW];
        end

        assign rd_data[l*LW +: LW] = mem[addr];
    end

endmodule

// File: rtl/nw_burst_sram.sv
module nw_burst_sram
    import nwsram_pkg::*;
#(
    parameter int AW      = 6,
    parameter int LANES   = 2,
    parameter int LW      = 8,
    parameter int LATENCY = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en_n,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                load_n,
    input  logic                wr_n,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic                out_en_n,
    input  logic                order_ilv,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic                rdata_oe
);

    localparam int DW = LANES * LW;

    logic             adv_en;
    logic             sel_ok;
    op_e              iss_op;
    logic [AW-1:0]    iss_addr;
    logic             burst_live;
    beat_t            burst_cnt;
    op_e              ex_op;
    logic [AW-1:0]    ex_addr;
    logic [LANES-1:0] ex_lane_n;
    logic [DW-1:0]    rd_data;
    logic [DW-1:0]    rdata_q;
    logic             rd_live_q;

    assign adv_en = ~clk_en_n;
    assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

    nwsram_cmd #(.AW(AW)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .adv_en     (adv_en),
        .sel_ok     (sel_ok),
        .load_n     (load_n),
        .wr_n       (wr_n),
        .ilv        (order_ilv),
        .addr       (addr),
        .iss_op     (iss_op),
        .iss_addr   (iss_addr),
        .burst_live (burst_live),
        .burst_cnt  (burst_cnt)
    );

    nwsram_pipe #(.AW(AW), .LANES(LANES), .STAGES(LATENCY)) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .en         (adv_en),
        .in_op      (iss_op),
        .in_addr    (iss_addr),
        .in_lane_n  (lane_wr_n),
        .out_op     (ex_op),
        .out_addr   (ex_addr),
        .out_lane_n (ex_lane_n)
    );

    nwsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk     (clk),
        .en      (adv_en),
        .wr      (ex_op == OP_WRITE),
        .addr    (ex_addr),
        .lane_n  (ex_lane_n),
        .wdata   (wdata),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_live_q <= 1'b0;
            rdata_q   <= '0;
        end else if (adv_en) begin
            rd_live_q <= (ex_op == OP_READ);
            if (ex_op == OP_READ) rdata_q <= rd_data;
        end
    end

    assign rdata    = rdata_q;
    assign rdata_oe = rd_live_q & ~out_en_n;

endmodule

// File: rtl/nwsram_chk.sv
module nwsram_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          load_n,
    input logic          out_en_n,
    input logic          rdata_oe,
    input logic [DW-1:0] rdata,
    input logic          burst_live,
    input logic [1:0]    burst_cnt
);

    logic sel_good;
    assign sel_good = ~sel_a_n & sel_b & ~sel_c_n;

    p_bad_select_r1: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && !sel_good) |=> !burst_live);

    p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n) |=> (burst_cnt == 2'd0));

    p_beat_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && load_n && burst_live) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(rdata) && $stable(burst_cnt) && $stable(burst_live)));

    p_desel_stays_r8: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && load_n && !burst_live) |=> !burst_live);

    p_oe_gate_r9: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_oe);

endmodule

bind nw_burst_sram nwsram_chk #(.DW(LANES*LW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .load_n     (load_n),
    .out_en_n   (out_en_n),
    .rdata_oe   (rdata_oe),
    .rdata      (rdata),
    .burst_live (burst_live),
    .burst_cnt  (burst_cnt)
);

// File: tb/nw_burst_sram_tb.sv
module nw_burst_sram_tb;

    localparam int AW = 5;
    localparam int LANES = 2;
    localparam int LW = 8;
    localparam int DW = LANES * LW;
    localparam logic [2:0] SG = 3'b010;   // {sel_a_n, sel_b, sel_c_n} selected
    localparam logic [2:0] SB = 3'b110;   // not selected

    typedef struct packed {
        logic        load_n;
        logic        wr_n;
        logic [2:0]  sel;
        logic [1:0]  lane_n;
        logic        oe_n;
        logic        ilv;
        logic [4:0]  addr;
        logic [15:0] wdata;
        logic        exp_oe;
        logic [15:0] exp_data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        // R4 R7: interleaved write burst from 5 -> words 5,4,7,6
        '{1'b0,1'b0,SG,2'b00,1'b0,1'b1,5'h05,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b1,1'b0,SG,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b0,16'h0000,4'd2},
        '{1'b1,1'b0,SG,2'b00,1'b0,1'b1,5'h00,16'h1111,1'b0,16'h0000,4'd2},
        '{1'b1,1'b0,SG,2'b00,1'b0,1'b1,5'h00,16'h2222,1'b0,16'h0000,4'd2},
        // R6: read right after write, no idle cycle; burst from 4 -> 4,5,6,7
        '{1'b0,1'b1,SG,2'b00,1'b0,1'b1,5'h04,16'h3333,1'b0,16'h0000,4'd6},
        '{1'b1,1'b1,SG,2'b00,1'b0,1'b1,5'h00,16'h4444,1'b0,16'h0000,4'd2},
        '{1'b1,1'b1,SG,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h2222,4'd6},
        '{1'b1,1'b1,SG,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h1111,4'd7},
        // R1: load with bad selects deselects
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h4444,4'd7},
        // R8: continue after deselect stays deselected even with good selects
        '{1'b1,1'b1,SG,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h3333,4'd7},
        '{1'b1,1'b1,SG,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b0,16'h0000,4'd1},
        '{1'b1,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b0,16'h0000,4'd8},
        // R6: write word 9 then read it on the next cycle
        '{1'b0,1'b0,SG,2'b00,1'b0,1'b1,5'h09,16'h0000,1'b0,16'h0000,4'd8},
        '{1'b0,1'b1,SG,2'b00,1'b0,1'b1,5'h09,16'h0000,1'b0,16'h0000,4'd1},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'hABCD,1'b0,16'h0000,4'd6},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'hABCD,4'd6},
        // R7: linear write burst from 0x0E -> 0E,0F,0C
        '{1'b0,1'b0,SG,2'b00,1'b0,1'b0,5'h0E,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b1,1'b0,SG,2'b00,1'b0,1'b0,5'h00,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b1,1'b0,SG,2'b00,1'b0,1'b0,5'h00,16'h0E0E,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0F0F,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0C0C,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SG,2'b00,1'b0,1'b1,5'h0C,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h0C0C,4'd7},
        '{1'b0,1'b1,SG,2'b00,1'b0,1'b1,5'h0F,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h0F0F,4'd7},
        // R4: upper lane only to 0x0C; R5: all lanes masked to 0x0F
        '{1'b0,1'b0,SG,2'b01,1'b0,1'b1,5'h0C,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b0,1'b0,SG,2'b11,1'b0,1'b1,5'h0F,16'h0000,1'b0,16'h0000,4'd5},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h5577,1'b0,16'h0000,4'd4},
        '{1'b0,1'b1,SG,2'b00,1'b0,1'b1,5'h0C,16'hFFFF,1'b0,16'h0000,4'd5},
        '{1'b0,1'b1,SG,2'b00,1'b0,1'b1,5'h0F,16'h0000,1'b0,16'h0000,4'd5},
        '{1'b0,1'b1,SB,2'b00,1'b0,1'b1,5'h00,16'h0000,1'b1,16'h550C,4'd4},
        // R9: output disabled, read data not driven
        '{1'b0,1'b1,SB,2'b00,1'b1,1'b1,5'h00,16'h0000,1'b0,16'h0000,4'd9}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          clk_en_n;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          load_n, wr_n;
    logic [1:0]    lane_wr_n;
    logic          out_en_n;
    logic          order_ilv;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    nw_burst_sram #(.AW(AW), .LANES(LANES), .LW(LW), .LATENCY(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .clk_en_n  (clk_en_n),
        .sel_a_n   (sel_a_n),
        .sel_b     (sel_b),
        .sel_c_n   (sel_c_n),
        .load_n    (load_n),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .out_en_n  (out_en_n),
        .order_ilv (order_ilv),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual oe/data=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic w, input logic [2:0] s, input logic [1:0] ln,
                         input logic oe, input logic il, input logic [4:0] a, input logic [15:0] d);
        load_n = ld; wr_n = w; {sel_a_n, sel_b, sel_c_n} = s; lane_wr_n = ln;
        out_en_n = oe; order_ilv = il; addr = a; wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; clk_en_n = 1'b0;
        drive(1'b0, 1'b1, SB, 2'b11, 1'b0, 1'b1, 5'h00, 16'h0000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset state", {rdata_oe, 16'h0}, {1'b0, 16'h0});

        // Table walk: row inputs applied, one edge, outputs compared.
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            drive(v.load_n, v.wr_n, v.sel, v.lane_n, v.oe_n, v.ilv, v.addr, v.wdata);
            tick();
            check($sformatf("R%0d row %0d", v.req, i),
                  {rdata_oe, (v.exp_oe ? rdata : 16'h0)}, {v.exp_oe, v.exp_data});
            @(negedge clk);
        end

        // R3: stall between address and data with a would-be write on the inputs
        drive(1'b0, 1'b1, SG, 2'b00, 1'b0, 1'b1, 5'h0F, 16'h0000);
        tick(); @(negedge clk);
        clk_en_n = 1'b1;
        drive(1'b0, 1'b0, SG, 2'b00, 1'b0, 1'b1, 5'h0C, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R3 stall keeps output", {rdata_oe, 16'h0}, {1'b0, 16'h0});
            @(negedge clk);
        end
        clk_en_n = 1'b0;
        drive(1'b0, 1'b1, SB, 2'b00, 1'b0, 1'b1, 5'h00, 16'h0000);
        tick(); @(negedge clk);
        tick();
        check("R5 aborted write left word 0F", {rdata_oe, rdata}, {1'b1, 16'h0F0F});
        @(negedge clk);
        drive(1'b0, 1'b1, SG, 2'b00, 1'b0, 1'b1, 5'h0C, 16'h0000);
        tick(); @(negedge clk);
        drive(1'b0, 1'b1, SB, 2'b00, 1'b0, 1'b1, 5'h00, 16'h0000);
        tick(); @(negedge clk);
        tick();
        check("R3 stalled write ignored", {rdata_oe, rdata}, {1'b1, 16'h550C});

        // R9: output enable acts without a clock edge
        out_en_n = 1'b1; #1;
        check("R9 oe high stops drive", {rdata_oe, 16'h0}, {1'b0, 16'h0});
        out_en_n = 1'b0; #1;
        check("R9 oe low restores drive", {rdata_oe, rdata}, {1'b1, 16'h550C});
        @(negedge clk);

        // R9: dummy read issued with oe high, then oe low at output time
        drive(1'b0, 1'b1, SG, 2'b00, 1'b1, 1'b1, 5'h09, 16'h0000);
        tick(); @(negedge clk);
        drive(1'b0, 1'b1, SB, 2'b00, 1'b1, 1'b1, 5'h00, 16'h0000);
        tick(); @(negedge clk);
        tick();
        check("R9 dummy read not driven", {rdata_oe, 16'h0}, {1'b0, 16'h0});
        out_en_n = 1'b0; #1;
        check("R9 dummy read ran internally", {rdata_oe, rdata}, {1'b1, 16'hABCD});
        @(negedge clk);

        // R10 R8: reset while reads are in flight, then continue cycles
        drive(1'b0, 1'b1, SG, 2'b00, 1'b0, 1'b1, 5'h0C, 16'h0000);
        tick(); @(negedge clk);
        rst = 1'b1;
        tick(); @(negedge clk);
        rst = 1'b0;
        check("R10 reset clears drive", {rdata_oe, 16'h0}, {1'b0, 16'h0});
        drive(1'b1, 1'b1, SG, 2'b00, 1'b0, 1'b1, 5'h0C, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R8 no burst after reset", {rdata_oe, 16'h0}, {1'b0, 16'h0});
            @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule